// File: doc/BRIEF.md
# Dual Maskable Alarm Comparator

This block holds two independent alarm settings and compares each against the live calendar time delivered by an external timekeeping counter. Comparison happens only on the cycle in which a one-second strobe is high, so any matching second yields exactly one flag event. Each alarm carries six per-field enable bits (second, minute, hour, weekday, day-of-month, month), so a match can be tied to any subset of fields. A match sets that alarm's sticky flag, which the host polls and clears with a status-read strobe. An active-low, open-drain style interrupt line is pulled low while any flag whose alarm has its interrupt enable set is pending.

Each alarm is a three-state machine. `AL_IDLE` is the state after reset or after a write with every field enable clear. A write with at least one enable set takes the *program-arm* transition to `AL_ARMED`. A write with no enable set takes the *program-off* transition back to `AL_IDLE`. In `AL_ARMED`, a match on a tick with repeat mode set is the *repeat-fire* transition, which stays in `AL_ARMED`, so a seconds-only mask gives a periodic once-per-minute event. With repeat mode clear, a match takes the *one-shot-fire* transition to `AL_SPENT`. That state ignores further matches until the next write, which rearms the alarm. Alarm settings live in plain registers and are loaded one alarm at a time through a write strobe.

Top module: `alarm_pair_cmp`

## Requirements
- R1: After reset both flags read 0, `irq_n` is 1, and both alarms are in `AL_IDLE`, so no tick sets a flag until an alarm is written.
- R2: An alarm matches only when every field whose enable bit is set equals the live value. Enable bit positions are: bit 0 second, bit 1 minute, bit 2 hour, bit 3 weekday, bit 4 day-of-month, bit 5 month. Fields whose bit is clear are ignored.
- R3: An alarm written with all six enable bits clear never sets its flag.
- R4: Matching is evaluated only while `tick` is high. A matching time without `tick` sets nothing. A flag set by a match on `tick` is visible on `alarm_flag` from the next clock edge.
- R5: A flag is sticky. It stays at 1 until a cycle with `rd_clr` high, and that edge clears both flags.
- R6: When a match and `rd_clr` fall in the same cycle, the flag is 1 after that edge, so the event is not lost.
- R7: `irq_n` is 0 exactly while some alarm has its flag set and its interrupt enable set. A flag on an alarm whose interrupt enable is clear leaves `irq_n` at 1.
- R8: With repeat clear, an alarm fires once and then ignores matches until it is written again.
- R9: With repeat set, an alarm sets its flag on every matching tick, after each clear.
- R10: Writing one alarm (`wr_idx` 0 or 1) changes neither the other alarm's settings nor any pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second strobe, one cycle wide |
| now_sec | input | 6 | Live second, binary 0-59 |
| now_min | input | 6 | Live minute, binary 0-59 |
| now_hour | input | 5 | Live hour, binary 0-23 |
| now_dow | input | 3 | Live weekday, 0-6 |
| now_date | input | 5 | Live day of month, 1-31 |
| now_month | input | 4 | Live month, 1-12 |
| wr_en | input | 1 | Load the alarm selected by `wr_idx` |
| wr_idx | input | 1 | Alarm index for the write |
| wr_sec | input | 6 | Alarm second value |
| wr_min | input | 6 | Alarm minute value |
| wr_hour | input | 5 | Alarm hour value |
| wr_dow | input | 3 | Alarm weekday value |
| wr_date | input | 5 | Alarm day-of-month value |
| wr_month | input | 4 | Alarm month value |
| wr_mask | input | 6 | Field enables, positions as in R2 |
| wr_irq_en | input | 1 | Interrupt enable for the alarm |
| wr_repeat | input | 1 | Repeat mode (1) or one-shot (0) |
| rd_clr | input | 1 | Status read strobe, clears flags |
| alarm_flag | output | 2 | Sticky match flags, bit n for alarm n |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The two functions that can coincide are a match setting a flag and a status read clearing it. The stimulus table presents a tick whose time matches an alarm in the same cycle that `rd_clr` is high. The check passes only if the flag reads 1 afterwards and `irq_n` stays low. A neighbouring vector raises `rd_clr` with a non-matching time, which shows that the clear itself works, so a pass on the first vector cannot come from a clear that is never applied.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

    parameter int SEC_W  = 6;
    parameter int MIN_W  = 6;
    parameter int HOUR_W = 5;
    parameter int DOW_W  = 3;
    parameter int DATE_W = 5;
    parameter int MON_W  = 4;

    localparam int NFIELD = 6;

    // field enable bit positions
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DATE = 4;
    localparam int F_MON  = 5;

    typedef struct packed {
        logic [MON_W-1:0]  month;
        logic [DATE_W-1:0] date;
        logic [DOW_W-1:0]  dow;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_t;

    typedef enum logic [1:0] {
        AL_IDLE  = 2'd0,
        AL_ARMED = 2'd1,
        AL_SPENT = 2'd2
    } al_state_e;

endpackage

// File: rtl/alarm_field_match.sv
module alarm_field_match
    import alarm_cmp_pkg::*;
(
    input  cal_t              now,
    input  cal_t              target,
    input  logic [NFIELD-1:0] mask,
    output logic              hit
);

    logic [NFIELD-1:0] eq;

    always_comb begin
        eq         = '0;
        eq[F_SEC]  = (now.sec   == target.sec);
        eq[F_MIN]  = (now.min   == target.min);
        eq[F_HOUR] = (now.hour  == target.hour);
        eq[F_DOW]  = (now.dow   == target.dow);
        eq[F_DATE] = (now.date  == target.date);
        eq[F_MON]  = (now.month == target.month);
    end

    // a field counts only when enabled; an empty mask never matches
    assign hit = (|mask) && (&(eq | ~mask));

endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
    import alarm_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  cal_t              now,
    input  logic              wr_en,
    input  cal_t              wr_cal,
    input  logic [NFIELD-1:0] wr_mask,
    input  logic              wr_irq_en,
    input  logic              wr_repeat,
    input  logic              clr,
    output logic              flag,
    output logic              irq_en
);

    al_state_e         state_q, state_d;
    cal_t              cal_q;
    logic [NFIELD-1:0] mask_q;
    logic              ie_q;
    logic              rep_q;
    logic              flag_q;
    logic              hit;
    logic              fire;

    alarm_field_match u_match (
        .now    (now),
        .target (cal_q),
        .mask   (mask_q),
        .hit    (hit)
    );

    assign fire = tick && hit && (state_q == AL_ARMED);

    // settings registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q  <= '0;
            mask_q <= '0;
            ie_q   <= 1'b0;
            rep_q  <= 1'b0;
        end else if (wr_en) begin
            cal_q  <= wr_cal;
            mask_q <= wr_mask;
            ie_q   <= wr_irq_en;
            rep_q  <= wr_repeat;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AL_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            // program-arm / program-off
            state_d = (|wr_mask) ? AL_ARMED : AL_IDLE;
        end else begin
            unique case (state_q)
                AL_IDLE:  state_d = AL_IDLE;
                AL_ARMED: begin
                    // repeat-fire stays, one-shot-fire retires
                    if (fire && !rep_q) state_d = AL_SPENT;
                end
                AL_SPENT: state_d = AL_SPENT;
                default:  state_d = AL_IDLE;
            endcase
        end
    end

    // outputs: sticky flag, set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (fire)  flag_q <= 1'b1;
        else if (clr)   flag_q <= 1'b0;
    end

    assign flag   = flag_q;
    assign irq_en = ie_q;

    // R4
    flag_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick));

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);

    // R6
    match_not_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit && state_q == AL_ARMED) |=> flag_q);

    // R8
    one_shot_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == AL_ARMED && tick && hit && !rep_q && !wr_en) |=> (state_q == AL_SPENT));

    // R3
    empty_mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mask == '0) |=> (state_q == AL_IDLE));

endmodule

// File: rtl/alarm_pair_cmp.sv
module alarm_pair_cmp
    import alarm_cmp_pkg::*;
#(
    parameter int N_ALARMS = 2,
    parameter int IDX_W    = (N_ALARMS > 1) ? $clog2(N_ALARMS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [SEC_W-1:0]    now_sec,
    input  logic [MIN_W-1:0]    now_min,
    input  logic [HOUR_W-1:0]   now_hour,
    input  logic [DOW_W-1:0]    now_dow,
    input  logic [DATE_W-1:0]   now_date,
    input  logic [MON_W-1:0]    now_month,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [SEC_W-1:0]    wr_sec,
    input  logic [MIN_W-1:0]    wr_min,
    input  logic [HOUR_W-1:0]   wr_hour,
    input  logic [DOW_W-1:0]    wr_dow,
    input  logic [DATE_W-1:0]   wr_date,
    input  logic [MON_W-1:0]    wr_month,
    input  logic [NFIELD-1:0]   wr_mask,
    input  logic                wr_irq_en,
    input  logic                wr_repeat,
    input  logic                rd_clr,
    output logic [N_ALARMS-1:0] alarm_flag,
    output logic                irq_n
);

    cal_t              now_cal;
    cal_t              wr_cal;
    logic [N_ALARMS-1:0] ie_vec;

    always_comb begin
        now_cal.sec   = now_sec;
        now_cal.min   = now_min;
        now_cal.hour  = now_hour;
        now_cal.dow   = now_dow;
        now_cal.date  = now_date;
        now_cal.month = now_month;
        wr_cal.sec    = wr_sec;
        wr_cal.min    = wr_min;
        wr_cal.hour   = wr_hour;
        wr_cal.dow    = wr_dow;
        wr_cal.date   = wr_date;
        wr_cal.month  = wr_month;
    end

    for (genvar g = 0; g < N_ALARMS; g++) begin : g_alarm
        logic sel_wr;
        assign sel_wr = wr_en && (wr_idx == IDX_W'(g));

        alarm_unit u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .now       (now_cal),
            .wr_en     (sel_wr),
            .wr_cal    (wr_cal),
            .wr_mask   (wr_mask),
            .wr_irq_en (wr_irq_en),
            .wr_repeat (wr_repeat),
            .clr       (rd_clr),
            .flag      (alarm_flag[g]),
            .irq_en    (ie_vec[g])
        );
    end

    // open-drain style: driven low when asserted, released high otherwise
    assign irq_n = ~(|(alarm_flag & ie_vec));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag == '0) |-> irq_n);

endmodule

// File: tb/alarm_pair_cmp_test.sv
module alarm_pair_cmp_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [5:0] now_sec = '0;
    logic [5:0] now_min = '0;
    logic [4:0] now_hour = '0;
    logic [2:0] now_dow = '0;
    logic [4:0] now_date = '0;
    logic [3:0] now_month = '0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_idx = '0;
    logic [5:0] wr_sec = '0;
    logic [5:0] wr_min = '0;
    logic [4:0] wr_hour = '0;
    logic [2:0] wr_dow = '0;
    logic [4:0] wr_date = '0;
    logic [3:0] wr_month = '0;
    logic [5:0] wr_mask = '0;
    logic       wr_irq_en = 1'b0;
    logic       wr_repeat = 1'b0;
    logic       rd_clr = 1'b0;
    logic [1:0] alarm_flag;
    logic       irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_pair_cmp uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_dow(now_dow), .now_date(now_date), .now_month(now_month),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sec(wr_sec), .wr_min(wr_min),
        .wr_hour(wr_hour), .wr_dow(wr_dow), .wr_date(wr_date), .wr_month(wr_month),
        .wr_mask(wr_mask), .wr_irq_en(wr_irq_en), .wr_repeat(wr_repeat),
        .rd_clr(rd_clr), .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    // vector: {sec[18:13], min[12:7], dow[6:4], clr[3], exp_flags[2:1], exp_irq_n[0]}
    // alarm0: sec 30 + min 15 enabled, irq on, repeat; alarm1: weekday 3 only, irq off, one-shot
    localparam int NVEC = 8;
    localparam logic [18:0] VEC [NVEC] = '{
        {6'd30, 6'd14, 3'd1, 1'b0, 2'b00, 1'b1},  // R2 minute differs
        {6'd30, 6'd15, 3'd1, 1'b0, 2'b01, 1'b0},  // R2 R7 alarm0 hits
        {6'd31, 6'd15, 3'd1, 1'b1, 2'b00, 1'b1},  // R5 read clears
        {6'd30, 6'd15, 3'd3, 1'b0, 2'b11, 1'b0},  // R10 both hit, R9 again
        {6'd0,  6'd0,  3'd3, 1'b1, 2'b00, 1'b1},  // R8 alarm1 spent
        {6'd30, 6'd15, 3'd3, 1'b0, 2'b01, 1'b0},  // R8 R9 only alarm0
        {6'd30, 6'd15, 3'd2, 1'b1, 2'b01, 1'b0},  // R6 set with clear
        {6'd29, 6'd15, 3'd2, 1'b1, 2'b00, 1'b1}   // R5 clear
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic prog(input logic idx, input logic [5:0] s, input logic [5:0] m,
                        input logic [4:0] h, input logic [2:0] d, input logic [4:0] dt,
                        input logic [3:0] mo, input logic [5:0] mask,
                        input logic ie, input logic rep);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_sec = s; wr_min = m; wr_hour = h;
        wr_dow = d; wr_date = dt; wr_month = mo; wr_mask = mask;
        wr_irq_en = ie; wr_repeat = rep;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick(input logic [5:0] s, input logic [5:0] m,
                           input logic [2:0] d, input logic clr);
        @(negedge clk);
        now_sec = s; now_min = m; now_dow = d; tick = 1'b1; rd_clr = clr;
        @(negedge clk);
        tick = 1'b0; rd_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flags in reset", alarm_flag, 2'b00);
        chk("R1 irq_n in reset", irq_n, 1'b1);
        rst_n = 1'b1;
        do_tick(6'd0, 6'd0, 3'd0, 1'b0);
        chk("R1 idle after reset", alarm_flag, 2'b00);

        prog(1'b0, 6'd30, 6'd15, 5'd7, 3'd6, 5'd9, 4'd11, 6'b000011, 1'b1, 1'b1);
        prog(1'b1, 6'd5, 6'd5, 5'd5, 3'd3, 5'd5, 4'd5, 6'b001000, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            do_tick(VEC[i][18:13], VEC[i][12:7], VEC[i][6:4], VEC[i][3]);
            chk($sformatf("R2/R5/R6/R8/R9 vec%0d flags", i), alarm_flag, VEC[i][2:1]);
            chk($sformatf("R7 vec%0d irq_n", i), irq_n, VEC[i][0]);
        end

        // R10: writing alarm1 keeps alarm0 flag
        do_tick(6'd30, 6'd15, 3'd0, 1'b0);
        chk("R9 alarm0 refires", alarm_flag, 2'b01);
        prog(1'b1, 6'd5, 6'd5, 5'd5, 3'd3, 5'd5, 4'd5, 6'b001000, 1'b0, 1'b0);
        chk("R10 other flag kept", alarm_flag, 2'b01);
        do_tick(6'd0, 6'd0, 3'd0, 1'b1);
        chk("R5 cleared", alarm_flag, 2'b00);

        // R7: flag without interrupt enable leaves irq_n released
        do_tick(6'd0, 6'd0, 3'd3, 1'b0);
        chk("R8 rearmed by write", alarm_flag, 2'b10);
        chk("R7 irq_n masked", irq_n, 1'b1);
        do_tick(6'd0, 6'd0, 3'd0, 1'b1);

        // R3: empty mask never fires
        prog(1'b1, 6'd0, 6'd0, 5'd0, 3'd0, 5'd0, 4'd0, 6'b000000, 1'b1, 1'b1);
        do_tick(6'd0, 6'd0, 3'd0, 1'b0);
        do_tick(6'd59, 6'd59, 3'd6, 1'b0);
        chk("R3 empty mask", alarm_flag, 2'b00);
        chk("R3 irq_n", irq_n, 1'b1);

        // R4: matching time without tick does nothing
        @(negedge clk);
        now_sec = 6'd30; now_min = 6'd15;
        repeat (3) @(negedge clk);
        chk("R4 no tick", alarm_flag, 2'b00);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R4 single tick", alarm_flag, 2'b01);
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 one event per tick", alarm_flag, 2'b00);

        finish_run();
    end

endmodule